// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of five interrupt sources the core should service next. The sources are two external request lines, two timer overflow pulses and one serial port. The serial request is raised by either a receive flag or a transmit flag. Each source has its own enable bit and its own priority bit, and one global enable gates all of them. Two 8-bit registers hold these bits, and the core reads and writes them through a simple register port.

The controller latches incoming events as request flags. It masks them with the enables and picks one winner. It registers that winner's fixed vector address and level, and offers them to the core with `irq_valid`. When the core takes the vector, it pulses `irq_ack`. The controller then records the winner's level as in service, so only a request of strictly higher priority can interrupt the handler. A pulse on `irq_ret` closes the newest handler level.

Top module: `irq_arbiter`

## Requirements
- R1: The source indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1 and 4 = serial. The vector offered for source i is 0x0003 + 8*i, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R2: After a synchronous reset, all sources are disabled and at low priority, the global enable is off, no flag is pending, nothing is in service, `irq_valid` is 0 and `reg_rdata` is 0.
- R3: `reg_sel` = 0 selects the enable register and `reg_sel` = 1 selects the priority register. A write happens when `reg_wr` is 1. In the enable register, bits 0..4 are the per-source enables (bit = source index) and bit 7 is the global enable. In the priority register, bits 0..4 hold the per-source priority, where 1 means high. Unused bits read as 0. `reg_rdata` shows the selected register one cycle after the selection.
- R4: A pending source is offered only when its own enable and the global enable are both 1.
- R5: An eligible high-priority request always wins over an eligible low-priority one. Among requests at the same level, the lowest source index wins. `irq_level` is 1 for a high-level winner.
- R6: An event becomes visible on the outputs two clock edges after the cycle in which it occurs. The events are a rising edge on an `ext_line` bit, a one-cycle `tmr_ovf` pulse, and a `ser_rx_set` or `ser_tx_set` pulse.
- R7: `irq_ack` while `irq_valid` is 1 takes the offered vector. It marks that level as in service, clears the flag if the source is external or timer, and forces `irq_valid` to 0 on the next cycle. `irq_ack` while `irq_valid` is 0 has no effect.
- R8: While the low level is in service, only high-priority requests are offered. While the high level is in service, nothing is offered.
- R9: On `irq_ret`, the high in-service bit is cleared if it is set. Otherwise the low in-service bit is cleared.
- R10: The serial request is the OR of two flags: receive (set by `ser_rx_set`) and transmit (set by `ser_tx_set`). Both flags stay set when the vector is taken. They are cleared only by `ser_clr`, where bit 0 clears receive and bit 1 clears transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_line | input | 2 | External request lines; a rising edge raises the request |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_set | input | 1 | Sets the serial receive flag |
| ser_tx_set | input | 1 | Sets the serial transmit flag |
| ser_clr | input | 2 | Clears the serial flags (bit 0 receive, bit 1 transmit) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = priority register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register, registered |
| irq_valid | output | 1 | A vector is offered |
| irq_vector | output | 16 | Vector address of the winner |
| irq_level | output | 1 | Level of the winner, 1 = high |
| irq_ack | input | 1 | Core takes the offered vector |
| irq_ret | input | 1 | Return from the current handler |

## Verification
The bench sweeps every priority pattern against every pattern of pending sources, and every combination of the five source enables with the global enable. A wrong tie-break or a reversed level order in this sweep produces the wrong vector. A missing global gate offers a masked source. A directed nesting run starts a low-level handler, lets a high request preempt it, and then closes the levels one at a time. A design that pops the wrong level on return, or that lets an equal-level request in, offers a vector too early. Separate checks cover three more cases: serial flags that must survive a taken vector until cleared, an acknowledge that arrives with nothing offered, and reserved register bits that must read back as zero.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_PAIRS  = 2;
  localparam int NUM_SRC    = 2 * NUM_PAIRS + 1;
  localparam int SER_IDX    = 2 * NUM_PAIRS;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int VEC_W      = 16;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STEP   = 8;
  localparam int REG_W      = 8;
  localparam int GLOBAL_BIT = REG_W - 1;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] ext_line,
  input  logic [NUM_PAIRS-1:0] tmr_ovf,
  input  logic                 ser_rx_set,
  input  logic                 ser_tx_set,
  input  logic [1:0]           ser_clr,
  input  logic                 take,
  input  logic [IDX_W-1:0]     take_idx,
  output logic [NUM_SRC-1:0]   flags
);
  logic [NUM_PAIRS-1:0] ext_prev_q;
  logic [NUM_PAIRS-1:0] ext_flag_q;
  logic [NUM_PAIRS-1:0] tmr_flag_q;
  logic                 rx_q, tx_q;

  always_ff @(posedge clk) begin
    if (rst) ext_prev_q <= '0;
    else     ext_prev_q <= ext_line;
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic clr_ext, clr_tmr;
    assign clr_ext = take && (take_idx == IDX_W'(2 * k));
    assign clr_tmr = take && (take_idx == IDX_W'(2 * k + 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        ext_flag_q[k] <= 1'b0;
        tmr_flag_q[k] <= 1'b0;
      end else begin
        ext_flag_q[k] <= (ext_flag_q[k] & ~clr_ext) | (ext_line[k] & ~ext_prev_q[k]);
        tmr_flag_q[k] <= (tmr_flag_q[k] & ~clr_tmr) | tmr_ovf[k];
      end
    end
    assign flags[2 * k]     = ext_flag_q[k];
    assign flags[2 * k + 1] = tmr_flag_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= (rx_q & ~ser_clr[0]) | ser_rx_set;
      tx_q <= (tx_q & ~ser_clr[1]) | ser_tx_set;
    end
  end
  assign flags[SER_IDX] = rx_q | tx_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic ins_hi,
  output logic ins_lo
);
  logic hi_n, lo_n;

  always_comb begin
    hi_n = ins_hi;
    lo_n = ins_lo;
    if (ret) begin
      if (ins_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (take) begin
      if (take_hi) hi_n = 1'b1;
      else         lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= hi_n;
      ins_lo <= lo_n;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] ext_line,
  input  logic [NUM_PAIRS-1:0] tmr_ovf,
  input  logic                 ser_rx_set,
  input  logic                 ser_tx_set,
  input  logic [1:0]           ser_clr,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector,
  output logic                 irq_level,
  input  logic                 irq_ack,
  input  logic                 irq_ret
);
  logic [NUM_SRC-1:0] en_src_q, prio_q, flags, pend, hi_req, lo_req;
  logic               en_all_q;
  logic               ins_hi, ins_lo;
  logic               hi_found, lo_found;
  logic [IDX_W-1:0]   hi_idx, lo_idx, sel_idx, idx_q;
  logic               take;

  assign take = irq_ack & irq_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_src_q <= '0;
      en_all_q <= 1'b0;
      prio_q   <= '0;
    end else if (reg_wr) begin
      if (reg_sel) prio_q <= reg_wdata[NUM_SRC-1:0];
      else begin
        en_src_q <= reg_wdata[NUM_SRC-1:0];
        en_all_q <= reg_wdata[GLOBAL_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_sel) reg_rdata <= REG_W'(prio_q);
    else reg_rdata <= {en_all_q, (REG_W - 1 - NUM_SRC)'(0), en_src_q};
  end

  irq_flags u_flags (
    .clk(clk), .rst(rst), .ext_line(ext_line), .tmr_ovf(tmr_ovf),
    .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set), .ser_clr(ser_clr),
    .take(take), .take_idx(idx_q), .flags(flags)
  );

  assign pend   = flags & en_src_q & {NUM_SRC{en_all_q}};
  assign hi_req = pend & prio_q & {NUM_SRC{~ins_hi}};
  assign lo_req = pend & ~prio_q & {NUM_SRC{~(ins_hi | ins_lo)}};

  irq_pick u_pick_hi (.req(hi_req), .found(hi_found), .idx(hi_idx));
  irq_pick u_pick_lo (.req(lo_req), .found(lo_found), .idx(lo_idx));

  assign sel_idx = hi_found ? hi_idx : lo_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= 1'b0;
      idx_q      <= '0;
    end else if (take) begin
      irq_valid <= 1'b0;
    end else begin
      irq_valid  <= hi_found | lo_found;
      irq_vector <= vec_of(sel_idx);
      irq_level  <= hi_found;
      idx_q      <= sel_idx;
    end
  end

  irq_nest u_nest (
    .clk(clk), .rst(rst), .take(take), .take_hi(irq_level),
    .ret(irq_ret), .ins_hi(ins_hi), .ins_lo(ins_lo)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_level,
  input logic             irq_ack,
  input logic             irq_ret,
  input logic             ins_hi,
  input logic             ins_lo,
  input logic             en_all_q
);
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector[2:0] == 3'd3 && irq_vector < VEC_W'(VEC_BASE + VEC_STEP * NUM_SRC))); // R1
  AST_VALID_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(en_all_q)); // R4
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid) |=> !irq_valid); // R7
  AST_NO_HI_NEST: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(ins_hi)); // R8
  AST_NO_LO_NEST: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_level) |-> !$past(ins_lo)); // R8
  AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && ins_hi && !(irq_ack && irq_valid && irq_level)) |=> !ins_hi); // R9
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .irq_level(irq_level), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .ins_hi(ins_hi), .ins_lo(ins_lo), .en_all_q(en_all_q)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_line = '0, tmr_ovf = '0, ser_clr = '0;
  logic        ser_rx_set = 1'b0, ser_tx_set = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        irq_valid, irq_level;
  logic [15:0] irq_vector;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst(rst), .ext_line(ext_line), .tmr_ovf(tmr_ovf),
    .ser_rx_set(ser_rx_set), .ser_tx_set(ser_tx_set), .ser_clr(ser_clr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic raise(input logic [4:0] r, input bit use_tx);
    ext_line   = {r[2], r[0]};
    tmr_ovf    = {r[3], r[1]};
    ser_rx_set = r[4] & ~use_tx;
    ser_tx_set = r[4] & use_tx;
    step();
    ext_line = '0; tmr_ovf = '0; ser_rx_set = 1'b0; ser_tx_set = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    irq_ret = 1'b1; step(); irq_ret = 1'b0;
  endtask

  // expected {valid, level, vector} from requirement arithmetic
  function automatic logic [17:0] model(input logic [4:0] r, input logic [7:0] en, input logic [4:0] pr);
    logic [4:0] p;
    p = r & en[4:0] & {5{en[7]}};
    for (int i = 0; i < 5; i++)
      if (p[i] && pr[i]) return {1'b1, 1'b1, 16'(3 + 8 * i)};
    for (int i = 0; i < 5; i++)
      if (p[i]) return {1'b1, 1'b0, 16'(3 + 8 * i)};
    return 18'd0;
  endfunction

  task automatic trial(input string tag, input logic [4:0] r, input logic [7:0] en, input logic [4:0] pr);
    logic [17:0] e;
    do_reset();
    wr(1'b0, en);
    wr(1'b1, {3'b0, pr});
    raise(r, r[0]);
    step();
    e = model(r, en, pr);
    if (e[17]) check(tag, {irq_valid, irq_level, irq_vector}, e);
    else       check(tag, {15'd0, irq_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    do_reset();
    step();
    // R2: reset state
    check("R2 valid", {31'd0, irq_valid}, 32'd0);
    check("R2 rdata", {24'd0, reg_rdata}, 32'd0);

    // R3: register layout and readback of reserved bits
    wr(1'b0, 8'hFF);
    step();
    check("R3 enable readback", {24'd0, reg_rdata}, 32'h9F);
    wr(1'b1, 8'hFF);
    step();
    check("R3 priority readback", {24'd0, reg_rdata}, 32'h1F);

    // R1 R5 R6: every priority pattern against every request pattern
    for (int pr = 0; pr < 32; pr++)
      for (int r = 1; r < 32; r++)
        trial("R5 sweep", 5'(r), 8'h9F, 5'(pr));
    // R4: every enable combination including the global bit
    for (int e6 = 0; e6 < 64; e6++)
      trial("R4 enable sweep", 5'h1F, {e6[5], 2'b0, 5'(e6)}, 5'(e6 * 7));

    // R7 R8 R9: nesting, ext1 high, the rest low
    do_reset();
    wr(1'b0, 8'h9F);
    wr(1'b1, 8'h04);
    raise(5'b00010, 1'b0);
    step();
    check("R1 timer0 vector", {irq_valid, irq_level, irq_vector}, {14'd0, 2'b10, 16'h000B});
    pulse_ack();
    check("R7 valid drops after ack", {31'd0, irq_valid}, 32'd0);
    step();
    check("R7 timer flag cleared", {31'd0, irq_valid}, 32'd0);
    raise(5'b01000, 1'b0);
    step();
    check("R8 low does not preempt low", {31'd0, irq_valid}, 32'd0);
    raise(5'b00100, 1'b0);
    step();
    check("R8 high preempts low", {irq_valid, irq_level, irq_vector}, {14'd0, 2'b11, 16'h0013});
    pulse_ack();
    step();
    check("R8 nothing while high in service", {31'd0, irq_valid}, 32'd0);
    pulse_ret();
    step();
    check("R9 first return pops high only", {31'd0, irq_valid}, 32'd0);
    pulse_ret();
    step();
    check("R9 second return pops low", {irq_valid, irq_level, irq_vector}, {14'd0, 2'b10, 16'h001B});

    // R7: ack with nothing offered has no effect
    do_reset();
    wr(1'b0, 8'h9F);
    pulse_ack();
    raise(5'b00010, 1'b0);
    step();
    check("R7 stray ack ignored", {irq_valid, irq_level, irq_vector}, {14'd0, 2'b10, 16'h000B});

    // R10: serial flags persist until cleared
    do_reset();
    wr(1'b0, 8'h9F);
    raise(5'b10000, 1'b1);
    step();
    check("R10 serial via tx", {irq_valid, irq_vector}, {15'd0, 1'b1, 16'h0023});
    pulse_ack();
    step();
    check("R10 serial blocked in service", {31'd0, irq_valid}, 32'd0);
    pulse_ret();
    step();
    check("R10 serial flag kept after take", {irq_valid, irq_vector}, {15'd0, 1'b1, 16'h0023});
    ser_clr = 2'b01; step(); ser_clr = 2'b00;
    step();
    check("R10 rx clear leaves tx", {31'd0, irq_valid}, 32'd1);
    ser_clr = 2'b10; step(); ser_clr = 2'b00;
    step();
    check("R10 cleared", {31'd0, irq_valid}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule